// File: doc/BRIEF.md
# Sixteen-bit Capture/Compare Timer

A 16-bit counter peripheral on an 8-bit register bus. A clock-select field picks the count enable: none (the counter freezes), an internal prescaled enable strobe, or the rising or falling edge of an external clock pin that is first synchronized to the system clock. Four counting modes set how the counter wraps: a free-running up count, up counts that restart at a TOP taken from compare register A or from the capture register, and an up/down count that turns around at compare register A and at zero.

Two compare channels each hold a CPU-visible buffer and an active value. The buffer moves to the active value at a mode-dependent point in the count, so a period or duty change never cuts a cycle short. A match drives a per-channel waveform pin through a selectable action. One capture channel takes its event from a pin or from an analog-comparator level. The event passes through an optional four-sample noise filter and an edge selector, and then copies the counter into the capture register. Overflow, the two compare matches and capture each set a flag. A mask gates each flag onto an interrupt line. A flag is cleared by writing one to it or by its acknowledge strobe.

Top module: `tmr16_cc`

## Requirements
- R1: 16-bit registers are reached as byte pairs: low byte at the even address, high byte at the next odd one. A high-byte write lands in one shared temporary byte, and the low-byte write commits {temporary, low} in one cycle. A low-byte read returns the low byte and loads the high byte into the temporary byte, which any high-byte read then returns.
- R2: After reset every register, the counter, all flags, irq_o and wave_o are zero.
- R3: Control register 0 (address 0) bits [1:0] select the count enable: 0 none, where the counter holds its value; 1 each cycle with pre_en_i high; 2 each falling edge of ext_clk_i; 3 each rising edge of ext_clk_i. The pin is synchronized, and each edge gives exactly one count.
- R4: Mode (control 0 bits [3:2]) 0 counts up and wraps from 0xFFFF to 0, setting the overflow flag. In this mode a compare write takes effect at once.
- R5: Mode 1 counts up to compare A and mode 2 counts up to the capture register. On the next count after reaching TOP, the counter returns to 0 and sets the overflow flag.
- R6: Mode 3 counts up to compare A and then down to 0. The count that leaves 0 going up again sets the overflow flag.
- R7: In modes 1 and 2 a written compare value becomes active on the count that restarts from TOP. In mode 3 it becomes active on the count that turns at zero.
- R8: A count taken while the counter equals a channel's active value sets that channel's flag (A bit 1, B bit 2 of the flag register at address 2). It also applies the action from control register 1 (address 1): A in bits [1:0], B in bits [3:2], 0 none, 1 toggle, 2 clear, 3 set.
- R9: The capture event copies the counter into the capture register and sets flag bit 3. Control 0 bit 4 picks the edge (1 rising, 0 falling) and bit 6 picks the source (1 comparator, 0 pin). In mode 2 a capture event changes neither the register nor the flag.
- R10: With control 0 bit 5 set, the capture input changes level only after four equal consecutive samples, so a shorter pulse produces no capture.
- R11: Flag bit 0 is overflow. Writing a one to a flag bit clears it, and so does ack_i on that bit. irq_o equals the flags ANDed with the mask register at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data for addr_i |
| pre_en_i | input | 1 | Internal prescaled count enable |
| ext_clk_i | input | 1 | External count clock pin |
| cap_pin_i | input | 1 | Capture pin |
| acmp_i | input | 1 | Analog comparator level |
| ack_i | input | 4 | Per-flag interrupt acknowledge |
| irq_o | output | 4 | Masked interrupt requests |
| wave_o | output | 2 | Compare waveform outputs A, B |

## Verification
The bench changes a compare value in the middle of a period and checks that the old TOP still ends that period. A design that loads the buffer at once would wrap early or run past the new value. It walks the up/down turn points one count at a time: a counter that turns one count late overshoots compare A, and one that flags overflow at the wrong point sets the bit one step early. It also checks the shared temporary byte across reads. A design that latched on the high-byte read would return a stale half. Further checks confirm that a two-cycle glitch is filtered out, that the edge opposite the selected one produces no capture, and that mode 2 leaves the capture register untouched.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {CS_OFF, CS_INT, CS_EXT_FALL, CS_EXT_RISE} cs_e;
  typedef enum logic [1:0] {MD_NORM, MD_CLR_A, MD_CLR_CAP, MD_UPDN} md_e;
  typedef enum logic [1:0] {WA_NONE, WA_TOG, WA_CLR, WA_SET} wa_e;

  localparam int unsigned NUM_FLG  = 4;
  localparam int unsigned FLG_OVF  = 0;
  localparam int unsigned FLG_CMPA = 1;
  localparam int unsigned FLG_CMPB = 2;
  localparam int unsigned FLG_CAP  = 3;

  localparam logic [3:0] A_CTL0 = 4'd0;
  localparam logic [3:0] A_CTL1 = 4'd1;
  localparam logic [3:0] A_FLG  = 4'd2;
  localparam logic [3:0] A_MSK  = 4'd3;
  localparam logic [3:0] A_CNT  = 4'd4;
  localparam logic [3:0] A_OCA  = 4'd6;
  localparam logic [3:0] A_ICR  = 4'd10;
endpackage

// File: rtl/tmr16_clksel.sv
module tmr16_clksel
  import tmr16_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cs_e  cs_i,
  input  logic pre_en_i,
  input  logic ext_i,
  output logic tick_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sync_q[SYNC_N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], ext_i};
      prev_q <= lvl;
    end
  end

  always_comb begin
    unique case (cs_i)
      CS_INT:      tick_o = pre_en_i;
      CS_EXT_FALL: tick_o = prev_q & ~lvl;
      CS_EXT_RISE: tick_o = lvl & ~prev_q;
      default:     tick_o = 1'b0;
    endcase
  end

  AST_EXT_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cs_i == CS_EXT_FALL || cs_i == CS_EXT_RISE) && tick_o)
      |=> (!tick_o || cs_i == CS_INT)) // R3
    else $error("ext edge gave more than one tick");
endmodule

// File: rtl/tmr16_capin.sv
module tmr16_capin #(
  parameter int unsigned SYNC_N = 2,
  parameter int unsigned FILT_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_acmp_i,
  input  logic pin_i,
  input  logic acmp_i,
  input  logic filt_en_i,
  input  logic rise_i,
  output logic cap_o
);
  logic [SYNC_N-1:0] sync_q;
  logic [FILT_N-1:0] hist_q;
  logic              lvl_q, prev_q, raw;

  assign raw = src_acmp_i ? acmp_i : pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= '0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], raw};
      hist_q <= {hist_q[FILT_N-2:0], sync_q[SYNC_N-1]};
      prev_q <= lvl_q;
      if (!filt_en_i)      lvl_q <= sync_q[SYNC_N-1];
      else if (&hist_q)    lvl_q <= 1'b1;
      else if (~|hist_q)   lvl_q <= 1'b0;
    end
  end

  assign cap_o = rise_i ? (lvl_q & ~prev_q) : (prev_q & ~lvl_q);

  AST_CAP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !cap_o) // R9
    else $error("capture event longer than one cycle");

  AST_FILT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_en_i && !(&hist_q) && |hist_q) |=> $stable(lvl_q)) // R10
    else $error("filtered level moved on mixed samples");
endmodule

// File: rtl/tmr16_occh.sv
module tmr16_occh
  import tmr16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             imm_i,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  wa_e              act_i,
  output logic [CNT_W-1:0] buf_o,
  output logic [CNT_W-1:0] ocr_o,
  output logic             match_o,
  output logic             wave_o
);
  logic [CNT_W-1:0] buf_q, ocr_q;
  logic             wave_q;

  assign match_o = tick_i && (cnt_i == ocr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      ocr_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (wr_i && imm_i) ocr_q <= wdata_i;
      else if (load_i)   ocr_q <= buf_q;
      if (match_o) begin
        unique case (act_i)
          WA_TOG:  wave_q <= ~wave_q;
          WA_CLR:  wave_q <= 1'b0;
          WA_SET:  wave_q <= 1'b1;
          default: wave_q <= wave_q;
        endcase
      end
    end
  end

  assign buf_o  = buf_q;
  assign ocr_o  = ocr_q;
  assign wave_o = wave_q;

  AST_BUF_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_i && !load_i) |=> $stable(ocr_q)) // R7
    else $error("active compare changed outside its update point");
endmodule

// File: rtl/tmr16_cc.sv
module tmr16_cc
  import tmr16_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SYNC_N = 2,
  parameter int unsigned FILT_N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   addr_i,
  input  logic [7:0]   wdata_i,
  input  logic         we_i,
  input  logic         re_i,
  output logic [7:0]   rdata_o,
  input  logic         pre_en_i,
  input  logic         ext_clk_i,
  input  logic         cap_pin_i,
  input  logic         acmp_i,
  input  logic [3:0]   ack_i,
  output logic [3:0]   irq_o,
  output logic [1:0]   wave_o
);
  localparam int unsigned BYTE_W = CNT_W / 2;
  localparam int unsigned NUM_OC = 2;

  logic [7:0]         ctl0_q, ctl1_q;
  logic [NUM_FLG-1:0] msk_q, flg_q, flg_set, flg_clr;
  logic [BYTE_W-1:0]  tmp_q;
  logic [CNT_W-1:0]   cnt_q, icr_q, wdata16, top_val;
  logic               up_q;

  cs_e cs;
  md_e md;
  assign cs = cs_e'(ctl0_q[1:0]);
  assign md = md_e'(ctl0_q[3:2]);
  assign wdata16 = {tmp_q, wdata_i};

  logic wide_reg, hi_wr, lo_rd, cnt_wr, icr_wr, flg_wr;
  assign wide_reg = (addr_i >= A_CNT) && (addr_i <= A_ICR + 4'd1);
  assign hi_wr  = we_i && wide_reg && addr_i[0];
  assign lo_rd  = re_i && wide_reg && !addr_i[0];
  assign cnt_wr = we_i && (addr_i == A_CNT);
  assign icr_wr = we_i && (addr_i == A_ICR);
  assign flg_wr = we_i && (addr_i == A_FLG);

  logic tick, tick_eff, cap_raw, cap_ev;
  tmr16_clksel #(.SYNC_N(SYNC_N)) u_clksel (
    .clk_i, .rst_ni, .cs_i(cs), .pre_en_i, .ext_i(ext_clk_i), .tick_o(tick)
  );
  tmr16_capin #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_capin (
    .clk_i, .rst_ni, .src_acmp_i(ctl0_q[6]), .pin_i(cap_pin_i), .acmp_i,
    .filt_en_i(ctl0_q[5]), .rise_i(ctl0_q[4]), .cap_o(cap_raw)
  );
  assign tick_eff = tick && !cnt_wr;
  assign cap_ev   = cap_raw && (md != MD_CLR_CAP);

  // compare channels
  logic [CNT_W-1:0] oc_buf [NUM_OC];
  logic [CNT_W-1:0] oc_act [NUM_OC];
  logic [NUM_OC-1:0] oc_wr, oc_match;
  logic restart, bot_turn, oc_load;

  generate
    for (genvar g = 0; g < NUM_OC; g++) begin : g_oc
      assign oc_wr[g] = we_i && (addr_i == A_OCA + 4'(2 * g));
      tmr16_occh #(.CNT_W(CNT_W)) u_occh (
        .clk_i, .rst_ni,
        .wr_i(oc_wr[g]), .wdata_i(wdata16),
        .imm_i(md == MD_NORM), .load_i(oc_load),
        .tick_i(tick_eff), .cnt_i(cnt_q),
        .act_i(wa_e'(ctl1_q[2*g +: 2])),
        .buf_o(oc_buf[g]), .ocr_o(oc_act[g]),
        .match_o(oc_match[g]), .wave_o(wave_o[g])
      );
    end
  endgenerate

  // TOP select and turn points
  always_comb begin
    unique case (md)
      MD_CLR_A, MD_UPDN: top_val = oc_act[0];
      MD_CLR_CAP:        top_val = icr_q;
      default:           top_val = '1;
    endcase
  end

  logic at_top, at_bot;
  assign at_top   = cnt_q >= top_val;
  assign at_bot   = cnt_q == '0;
  assign restart  = tick_eff && (md != MD_UPDN) && at_top;
  assign bot_turn = tick_eff && (md == MD_UPDN) && !up_q && at_bot;
  assign oc_load  = (md == MD_UPDN) ? bot_turn : restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (cnt_wr) begin
      cnt_q <= wdata16;
    end else if (tick) begin
      if (md != MD_UPDN) begin
        cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      end else if (up_q) begin
        if (at_top) begin
          up_q  <= 1'b0;
          cnt_q <= at_bot ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (at_bot) begin
        up_q  <= 1'b1;
        cnt_q <= (top_val == '0) ? '0 : CNT_W'(1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // capture register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     icr_q <= '0;
    else if (icr_wr) icr_q <= wdata16;
    else if (cap_ev) icr_q <= cnt_q;
  end

  // flags
  always_comb begin
    flg_set = '0;
    flg_set[FLG_OVF]  = restart || bot_turn;
    flg_set[FLG_CMPA] = oc_match[0];
    flg_set[FLG_CMPB] = oc_match[1];
    flg_set[FLG_CAP]  = cap_ev;
    flg_clr = ack_i | (flg_wr ? wdata_i[NUM_FLG-1:0] : '0);
  end

  // control registers and shared temporary byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl0_q <= '0;
      ctl1_q <= '0;
      msk_q  <= '0;
      flg_q  <= '0;
      tmp_q  <= '0;
    end else begin
      if (we_i && addr_i == A_CTL0) ctl0_q <= wdata_i;
      if (we_i && addr_i == A_CTL1) ctl1_q <= wdata_i;
      if (we_i && addr_i == A_MSK)  msk_q  <= wdata_i[NUM_FLG-1:0];
      flg_q <= flg_set | (flg_q & ~flg_clr);
      if (hi_wr) begin
        tmp_q <= wdata_i;
      end else if (lo_rd) begin
        unique case (addr_i)
          A_CNT:        tmp_q <= cnt_q[CNT_W-1:BYTE_W];
          A_OCA:        tmp_q <= oc_buf[0][CNT_W-1:BYTE_W];
          A_OCA + 4'd2: tmp_q <= oc_buf[1][CNT_W-1:BYTE_W];
          default:      tmp_q <= icr_q[CNT_W-1:BYTE_W];
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTL0:       rdata_o = ctl0_q;
      A_CTL1:       rdata_o = ctl1_q;
      A_FLG:        rdata_o = 8'(flg_q);
      A_MSK:        rdata_o = 8'(msk_q);
      A_CNT:        rdata_o = cnt_q[BYTE_W-1:0];
      A_OCA:        rdata_o = oc_buf[0][BYTE_W-1:0];
      A_OCA + 4'd2: rdata_o = oc_buf[1][BYTE_W-1:0];
      A_ICR:        rdata_o = icr_q[BYTE_W-1:0];
      default:      rdata_o = wide_reg ? tmp_q : 8'h00;
    endcase
  end

  assign irq_o = flg_q & msk_q;

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs == CS_OFF && !cnt_wr) |=> $stable(cnt_q)) // R3
    else $error("counter moved with no clock source");

  AST_CAP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (md == MD_CLR_CAP && !icr_wr) |=> $stable(icr_q)) // R9
    else $error("capture register moved in mode 2");

  AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_wr && wdata_i[FLG_OVF] && !restart && !bot_turn) |=> !flg_q[FLG_OVF]) // R11
    else $error("overflow flag survived write-one clear");

  AST_B_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (md == MD_NORM && oc_wr[1]) |=> (oc_act[1] == $past(wdata16))) // R4
    else $error("mode 0 compare write not immediate");
endmodule

// File: tb/tmr16_cc_tb.sv
module tmr16_cc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] rdata;
  logic       pre_en = 1'b0, ext_clk = 1'b0, cap_pin = 1'b0, acmp = 1'b0;
  logic [3:0] ack = '0;
  logic [3:0] irq;
  logic [1:0] wave;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  tmr16_cc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pre_en_i(pre_en),
    .ext_clk_i(ext_clk), .cap_pin_i(cap_pin), .acmp_i(acmp),
    .ack_i(ack), .irq_o(irq), .wave_o(wave)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp=<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(a + 4'd1, v[15:8]);
    wr(a, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk); pre_en = 1'b1;
    repeat (n) @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {write, addr, data, expected read}
  typedef struct packed {
    logic       w;
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] e;
  } vec_t;
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0,  8'h00, 8'h00},  // R2 ctl0
    '{1'b0, 4'd2,  8'h00, 8'h00},  // R2 flags
    '{1'b0, 4'd4,  8'h00, 8'h00},  // R2 counter
    '{1'b1, 4'd7,  8'h12, 8'h00},  // R1 hi to temp
    '{1'b1, 4'd6,  8'h34, 8'h00},  // R1 commit
    '{1'b0, 4'd6,  8'h00, 8'h34},  // R1
    '{1'b0, 4'd7,  8'h00, 8'h12},  // R1
    '{1'b1, 4'd1,  8'h0D, 8'h00},
    '{1'b0, 4'd1,  8'h00, 8'h0D},
    '{1'b1, 4'd3,  8'h0F, 8'h00},
    '{1'b0, 4'd3,  8'h00, 8'h0F},  // R11 mask
    '{1'b1, 4'd11, 8'hAB, 8'h00},
    '{1'b1, 4'd10, 8'hCD, 8'h00},
    '{1'b0, 4'd10, 8'h00, 8'hCD},  // R1
    '{1'b0, 4'd11, 8'h00, 8'hAB}   // R1
  };

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    idle(3);
    chk("R2 irq", 32'(irq), 0);
    chk("R2 wave", 32'(wave), 0);
    rst_n = 1'b1;
    idle(2);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].w) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, b);
        chk($sformatf("R1/R2 vec%0d", i), 32'(b), 32'(VEC[i].e));
      end
    end
    wr(4'd1, 8'h00);
    wr(4'd3, 8'h00);

    // R3 stopped
    wr16(4'd4, 16'h0010);
    ticks(5);
    rd16(4'd4, v); chk("R3 stop holds", 32'(v), 32'h10);
    // R3 internal enable
    wr(4'd0, 8'h01);
    ticks(5);
    rd16(4'd4, v); chk("R3 internal", 32'(v), 32'h15);

    // R4 wrap
    wr16(4'd4, 16'hFFFE);
    wr(4'd2, 8'h0F);
    ticks(2);
    rd16(4'd4, v); chk("R4 wrap", 32'(v), 0);
    rd(4'd2, b);   chk("R4 ovf flag", 32'(b), 32'h01);
    wr(4'd2, 8'h01);
    rd(4'd2, b);   chk("R11 w1c", 32'(b), 0);

    // R8 mode 0 immediate compare B with set action
    wr(4'd1, 8'h0C);
    wr16(4'd8, 16'h0005);
    wr16(4'd4, 16'h0004);
    ticks(1);
    rd(4'd2, b); chk("R8 no early B", 32'(b), 0);
    chk("R8 wave B low", 32'(wave[1]), 0);
    ticks(1);
    rd(4'd2, b); chk("R8 B flag", 32'(b), 32'h04);
    chk("R8 wave B set", 32'(wave[1]), 1);

    // R11 mask and acknowledge
    wr(4'd3, 8'h04);
    idle(1); chk("R11 irq", 32'(irq), 32'h4);
    @(negedge clk); ack = 4'h4;
    @(negedge clk); ack = 4'h0;
    chk("R11 ack clears", 32'(irq), 0);
    wr(4'd3, 8'h00);

    // R5 mode 1 with toggle on A
    wr(4'd1, 8'h01);
    wr16(4'd6, 16'h0003);
    wr16(4'd4, 16'h0000);
    wr(4'd2, 8'h0F);
    wr(4'd0, 8'h05);
    ticks(4);
    rd16(4'd4, v); chk("R5 restart at A", 32'(v), 0);
    rd(4'd2, b);   chk("R5 ovf+A flags", 32'(b), 32'h03);
    chk("R8 wave A toggled", 32'(wave[0]), 1);

    // R7 buffered update
    ticks(1);
    wr16(4'd6, 16'h000A);
    ticks(2);
    rd16(4'd4, v); chk("R7 mid period", 32'(v), 3);
    ticks(1);
    rd16(4'd4, v); chk("R7 old TOP used", 32'(v), 0);
    ticks(5);
    rd16(4'd4, v); chk("R7 new TOP active", 32'(v), 5);

    // R6 up/down
    wr(4'd0, 8'h01);
    wr16(4'd6, 16'h0003);
    wr16(4'd4, 16'h0000);
    wr(4'd2, 8'h0F);
    wr(4'd0, 8'h0D);
    ticks(3);
    rd16(4'd4, v); chk("R6 at TOP", 32'(v), 3);
    ticks(3);
    rd16(4'd4, v); chk("R6 back to 0", 32'(v), 0);
    rd(4'd2, b);   chk("R6 no ovf yet", 32'(b & 8'h01), 0);
    ticks(1);
    rd16(4'd4, v); chk("R6 turn up", 32'(v), 1);
    rd(4'd2, b);   chk("R6 ovf", 32'(b & 8'h01), 1);

    // R3 external clock
    wr(4'd0, 8'h03);
    wr16(4'd4, 16'h0000);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); ext_clk = 1'b1; idle(4);
      ext_clk = 1'b0; idle(4);
    end
    rd16(4'd4, v); chk("R3 rising edges", 32'(v), 3);
    wr(4'd0, 8'h02);
    wr16(4'd4, 16'h0000);
    @(negedge clk); ext_clk = 1'b1; idle(6);
    rd16(4'd4, v); chk("R3 rising ignored", 32'(v), 0);
    ext_clk = 1'b0; idle(6);
    rd16(4'd4, v); chk("R3 falling", 32'(v), 1);

    // R9 capture
    wr(4'd0, 8'h10);
    wr16(4'd4, 16'h1234);
    wr(4'd2, 8'h0F);
    @(negedge clk); cap_pin = 1'b1; idle(6);
    rd16(4'd10, v); chk("R9 rising capture", 32'(v), 32'h1234);
    rd(4'd2, b);    chk("R9 cap flag", 32'(b), 32'h08);
    cap_pin = 1'b0; idle(6);
    wr(4'd0, 8'h00);
    wr16(4'd4, 16'h2222);
    wr(4'd2, 8'h0F);
    @(negedge clk); cap_pin = 1'b1; idle(6);
    rd(4'd2, b);    chk("R9 wrong edge", 32'(b), 0);
    cap_pin = 1'b0; idle(6);
    rd16(4'd10, v); chk("R9 falling capture", 32'(v), 32'h2222);
    wr(4'd0, 8'h50);
    wr16(4'd4, 16'h0777);
    @(negedge clk); acmp = 1'b1; idle(6);
    rd16(4'd10, v); chk("R9 comparator source", 32'(v), 32'h0777);
    acmp = 1'b0; idle(6);

    // R10 filter
    wr(4'd0, 8'h30);
    wr16(4'd4, 16'h0100);
    wr(4'd2, 8'h0F);
    @(negedge clk); cap_pin = 1'b1; idle(2);
    cap_pin = 1'b0; idle(10);
    rd(4'd2, b);    chk("R10 glitch dropped", 32'(b), 0);
    cap_pin = 1'b1; idle(10);
    rd16(4'd10, v); chk("R10 steady captured", 32'(v), 32'h0100);
    cap_pin = 1'b0; idle(10);

    // R9 mode 2 ignores capture, R5 TOP from capture register
    wr(4'd0, 8'h18);
    wr16(4'd10, 16'h0050);
    wr16(4'd4, 16'h0999);
    wr(4'd2, 8'h0F);
    @(negedge clk); cap_pin = 1'b1; idle(6);
    rd16(4'd10, v); chk("R9 mode2 no load", 32'(v), 32'h0050);
    rd(4'd2, b);    chk("R9 mode2 no flag", 32'(b), 0);
    cap_pin = 1'b0;
    wr(4'd0, 8'h19);
    wr16(4'd4, 16'h004E);
    ticks(3);
    rd16(4'd4, v); chk("R5 restart at capture TOP", 32'(v), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule